// File: doc/BRIEF.md
# Prioritized Interrupt Vector Fetcher

This block turns a set of pending interrupt and exception requests into a handler address. When idle, it ranks up to five request sources by a fixed priority, picks one and resolves its 8-bit type number. It then reads a four-byte entry from a 256-entry table in the lowest kilobyte of memory. The first of the two 16-bit words read is the handler offset (new instruction pointer). The second is the handler segment (new code segment).

The sources are a divide-error flag, a software-interrupt request carrying its own type, a non-maskable line, a maskable line whose type comes from the outside, and a single-step flag. The maskable line is gated by an enable flag. The non-maskable line is edge-captured and cannot be masked. Every source other than the non-maskable line is a level that the requester holds until it sees its own type delivered. The memory side is a simple request/response word port. Once both words are in, the block shows the result for one cycle with a strobe. It then stays parked, starting nothing new, until the consumer acknowledges.

Top module: `irq_vector_fetch`

## Requirements
- R1: When several sources are pending in the idle state, exactly one is chosen, in this fixed order from highest to lowest: divide error, software interrupt, non-maskable, maskable, single-step.
- R2: The delivered type is 0 for divide error, 1 for single-step, 2 for non-maskable, `soft_type` for a software interrupt and `mint_type` for a maskable request.
- R3: The maskable line has no effect while `mint_en` is low. It is taken while `mint_en` is high and the line is high, re-sampled every cycle. The non-maskable source ignores `mint_en`.
- R4: Each low-to-high transition of `nmi_in` produces exactly one service, however long the line stays high.
- R5: A fetch issues two single-cycle word reads. The first is at byte address type*4 (offset word). The second is at type*4+2 (segment word), and it is issued only in the cycle after the first read's data has returned with `rd_valid`. Example: type 3 reads 0x00C then 0x00E, and type 255 reads 0x3FC then 0x3FE.
- R6: After the second word returns, `vec_valid` is high for exactly one cycle. At that point `vec_ip` holds the first word read, `vec_cs` holds the second, and `vec_type` holds the served type.
- R7: From the start of a fetch until `svc_ack` is seen high (during or after the `vec_valid` cycle), no new source is chosen and no read is issued. The outputs `vec_type`, `vec_ip` and `vec_cs` hold steady while waiting.
- R8: Synchronous active-high reset leaves `rd_req` and `vec_valid` low, zeroes `vec_type`, `vec_ip` and `vec_cs`, and clears any captured non-maskable edge.
- R9: A non-maskable edge that arrives while a fetch is in progress is remembered and served after the current service is acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fault_div | input | 1 | Divide-error request (level) |
| soft_req | input | 1 | Software-interrupt request (level) |
| soft_type | input | 8 | Type number of the software interrupt |
| nmi_in | input | 1 | Non-maskable line, rising-edge captured |
| mint_req | input | 1 | Maskable interrupt line (level) |
| mint_type | input | 8 | Type number supplied with the maskable request |
| mint_en | input | 1 | Enable for the maskable line |
| trace_step | input | 1 | Single-step request (level) |
| rd_req | output | 1 | One-cycle word read request |
| rd_addr | output | 20 | Byte address of the word read |
| rd_valid | input | 1 | Read data valid, one cycle per request |
| rd_data | input | 16 | Read data word |
| svc_ack | input | 1 | Consumer acknowledge of the delivered vector |
| vec_valid | output | 1 | One-cycle strobe: vector outputs are new |
| vec_type | output | 8 | Type number of the served source |
| vec_ip | output | 16 | Handler offset (first word of the entry) |
| vec_cs | output | 16 | Handler segment (second word of the entry) |

## Verification
On every cycle, the assertions check these properties:
- at most one source is granted;
- a maskable grant never happens with the enable low;
- a captured non-maskable edge is cleared once served;
- read requests and the valid strobe are single-cycle pulses;
- the delivered vector stays frozen while acknowledge is pending.

Only the bench scenarios can show the rest: the full priority ordering when all five sources are raised together, that a held non-maskable level gives one service and not more, that an edge landing mid-fetch is served afterwards, and that the table addresses and the offset/segment word order are right at the boundary types.

// File: rtl/ivf_pkg.sv
package ivf_pkg;

    localparam int TYPE_W  = 8;
    localparam int NUM_SRC = 5;

    // Source slots, index 0 is the highest priority
    localparam int IDX_DIV  = 0;
    localparam int IDX_SOFT = 1;
    localparam int IDX_NMI  = 2;
    localparam int IDX_MINT = 3;
    localparam int IDX_STEP = 4;

    typedef logic [TYPE_W-1:0] vtype_t;

    localparam vtype_t TYPE_DIV  = vtype_t'(0);
    localparam vtype_t TYPE_STEP = vtype_t'(1);
    localparam vtype_t TYPE_NMI  = vtype_t'(2);

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ISSUE_LO,
        ST_WAIT_LO,
        ST_ISSUE_HI,
        ST_WAIT_HI,
        ST_SHOW,
        ST_HOLD
    } fetch_st_e;

    // Byte offset of a table entry from the table base
    function automatic int unsigned entry_offset(vtype_t t, int unsigned entry_bytes);
        return int'(t) * entry_bytes;
    endfunction

endpackage

// File: rtl/ivf_nmi_latch.sv
module ivf_nmi_latch (
    input  logic clk,
    input  logic rst,
    input  logic nmi_in,
    input  logic take,
    output logic pend
);
    logic nmi_q;
    logic edge_seen;

    assign edge_seen = nmi_in && !nmi_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            nmi_q <= 1'b0;
            pend  <= 1'b0;
        end else begin
            nmi_q <= nmi_in;
            if (edge_seen)
                pend <= 1'b1;
            else if (take)
                pend <= 1'b0;
        end
    end

    // R4: one service per edge, the latch empties once served
    a_r4_clear_on_take: assert property (@(posedge clk) disable iff (rst)
        (take && !edge_seen) |=> !pend);

    // R9: an edge is never lost, whatever the fetch state
    a_r9_edge_captured: assert property (@(posedge clk) disable iff (rst)
        edge_seen |=> pend);

endmodule

// File: rtl/ivf_prio_arb.sv
module ivf_prio_arb #(
    parameter int N_SRC = 5,
    parameter int TW    = 8
) (
    input  logic [N_SRC-1:0]         req,
    input  logic [N_SRC-1:0][TW-1:0] src_type,
    output logic [N_SRC-1:0]         gnt,
    output logic                     any,
    output logic [TW-1:0]            sel_type
);
    genvar g;
    generate
        for (g = 0; g < N_SRC; g++) begin : g_rank
            if (g == 0) begin : g_top
                assign gnt[g] = req[g];
            end else begin : g_low
                assign gnt[g] = req[g] && !(|req[g-1:0]);
            end
        end
    endgenerate

    assign any = |req;

    always_comb begin
        sel_type = '0;
        for (int i = 0; i < N_SRC; i++) begin
            if (gnt[i])
                sel_type = sel_type | src_type[i];
        end
    end

    // R1: never more than one winner
    always_comb begin
        a_r1_single_grant: assert ($onehot0(gnt));
    end

endmodule

// File: rtl/ivf_fetch_seq.sv
module ivf_fetch_seq
    import ivf_pkg::*;
#(
    parameter int ADDR_W      = 20,
    parameter int WORD_W      = 16,
    parameter int ENTRY_BYTES = 4,
    parameter int TABLE_BASE  = 0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  vtype_t            start_type,
    output logic              idle,
    output logic              rd_req,
    output logic [ADDR_W-1:0] rd_addr,
    input  logic              rd_valid,
    input  logic [WORD_W-1:0] rd_data,
    input  logic              ack,
    output logic              vec_valid,
    output vtype_t            vec_type,
    output logic [WORD_W-1:0] vec_ip,
    output logic [WORD_W-1:0] vec_cs
);
    localparam int WORD_BYTES = WORD_W / 8;

    fetch_st_e         state;
    logic [ADDR_W-1:0] entry_addr;

    assign entry_addr = ADDR_W'(TABLE_BASE) +
                        ADDR_W'(entry_offset(vec_type, ENTRY_BYTES));

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            vec_type <= '0;
            vec_ip   <= '0;
            vec_cs   <= '0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (start) begin
                        vec_type <= start_type;
                        state    <= ST_ISSUE_LO;
                    end
                end
                ST_ISSUE_LO: state <= ST_WAIT_LO;
                ST_WAIT_LO: begin
                    if (rd_valid) begin
                        vec_ip <= rd_data;
                        state  <= ST_ISSUE_HI;
                    end
                end
                ST_ISSUE_HI: state <= ST_WAIT_HI;
                ST_WAIT_HI: begin
                    if (rd_valid) begin
                        vec_cs <= rd_data;
                        state  <= ST_SHOW;
                    end
                end
                ST_SHOW: state <= ack ? ST_IDLE : ST_HOLD;
                ST_HOLD: if (ack) state <= ST_IDLE;
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign idle      = (state == ST_IDLE);
    assign vec_valid = (state == ST_SHOW);
    assign rd_req    = (state == ST_ISSUE_LO) || (state == ST_ISSUE_HI);
    assign rd_addr   = (state == ST_ISSUE_HI) ? entry_addr + ADDR_W'(WORD_BYTES)
                                              : entry_addr;

    // R5: every read request lasts a single cycle
    a_r5_req_pulse: assert property (@(posedge clk) disable iff (rst)
        rd_req |=> !rd_req);

    // R6: the result strobe lasts a single cycle
    a_r6_valid_pulse: assert property (@(posedge clk) disable iff (rst)
        vec_valid |=> !vec_valid);

    // R7: delivered vector frozen until acknowledged
    a_r7_hold_stable: assert property (@(posedge clk) disable iff (rst)
        (vec_valid && !ack) |=> ($stable(vec_type) && $stable(vec_ip) && $stable(vec_cs)));

    // R7: no fetch starts while the previous one is unacknowledged
    a_r7_no_read_waiting: assert property (@(posedge clk) disable iff (rst)
        (state == ST_HOLD && !ack) |=> !rd_req);

endmodule

// File: rtl/irq_vector_fetch.sv
module irq_vector_fetch
    import ivf_pkg::*;
#(
    parameter int ADDR_W      = 20,
    parameter int WORD_W      = 16,
    parameter int ENTRY_BYTES = 4,
    parameter int TABLE_BASE  = 0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              fault_div,
    input  logic              soft_req,
    input  logic [7:0]        soft_type,
    input  logic              nmi_in,
    input  logic              mint_req,
    input  logic [7:0]        mint_type,
    input  logic              mint_en,
    input  logic              trace_step,
    output logic              rd_req,
    output logic [ADDR_W-1:0] rd_addr,
    input  logic              rd_valid,
    input  logic [WORD_W-1:0] rd_data,
    input  logic              svc_ack,
    output logic              vec_valid,
    output logic [7:0]        vec_type,
    output logic [WORD_W-1:0] vec_ip,
    output logic [WORD_W-1:0] vec_cs
);
    logic [NUM_SRC-1:0]             req_vec;
    logic [NUM_SRC-1:0][TYPE_W-1:0] type_vec;
    logic [NUM_SRC-1:0]             gnt;
    logic                           any_req;
    vtype_t                         win_type;
    logic                           seq_idle;
    logic                           start;
    logic                           nmi_pend;
    logic                           take_nmi;

    always_comb begin
        req_vec           = '0;
        req_vec[IDX_DIV]  = fault_div;
        req_vec[IDX_SOFT] = soft_req;
        req_vec[IDX_NMI]  = nmi_pend;
        req_vec[IDX_MINT] = mint_req && mint_en;
        req_vec[IDX_STEP] = trace_step;

        type_vec           = '0;
        type_vec[IDX_DIV]  = TYPE_DIV;
        type_vec[IDX_SOFT] = soft_type;
        type_vec[IDX_NMI]  = TYPE_NMI;
        type_vec[IDX_MINT] = mint_type;
        type_vec[IDX_STEP] = TYPE_STEP;
    end

    assign start    = seq_idle && any_req;
    assign take_nmi = start && gnt[IDX_NMI];

    ivf_nmi_latch u_nmi (
        .clk    (clk),
        .rst    (rst),
        .nmi_in (nmi_in),
        .take   (take_nmi),
        .pend   (nmi_pend)
    );

    ivf_prio_arb #(
        .N_SRC (NUM_SRC),
        .TW    (TYPE_W)
    ) u_arb (
        .req      (req_vec),
        .src_type (type_vec),
        .gnt      (gnt),
        .any      (any_req),
        .sel_type (win_type)
    );

    ivf_fetch_seq #(
        .ADDR_W      (ADDR_W),
        .WORD_W      (WORD_W),
        .ENTRY_BYTES (ENTRY_BYTES),
        .TABLE_BASE  (TABLE_BASE)
    ) u_seq (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .start_type (win_type),
        .idle       (seq_idle),
        .rd_req     (rd_req),
        .rd_addr    (rd_addr),
        .rd_valid   (rd_valid),
        .rd_data    (rd_data),
        .ack        (svc_ack),
        .vec_valid  (vec_valid),
        .vec_type   (vec_type),
        .vec_ip     (vec_ip),
        .vec_cs     (vec_cs)
    );

    // R3: a maskable grant requires the enable
    a_r3_mask_respected: assert property (@(posedge clk) disable iff (rst)
        gnt[IDX_MINT] |-> mint_en);

    // R1: a lower source never wins over a pending divide error
    a_r1_div_first: assert property (@(posedge clk) disable iff (rst)
        fault_div |-> (gnt == NUM_SRC'(1)));

    // R2: a non-maskable grant yields type 2
    a_r2_nmi_type: assert property (@(posedge clk) disable iff (rst)
        gnt[IDX_NMI] |-> (win_type == TYPE_NMI));

    // R2: a single-step-only grant yields type 1
    a_r2_step_type: assert property (@(posedge clk) disable iff (rst)
        gnt[IDX_STEP] |-> (win_type == TYPE_STEP));

endmodule

// File: tb/irq_vector_fetch_test.sv
`timescale 1ns/1ps
module irq_vector_fetch_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        fault_div = 0, soft_req = 0, nmi_in = 0, mint_req = 0, mint_en = 0, trace_step = 0;
    logic [7:0]  soft_type = 0, mint_type = 0;
    logic        rd_req, rd_valid = 0, svc_ack = 0, vec_valid;
    logic [19:0] rd_addr;
    logic [15:0] rd_data = 0, vec_ip, vec_cs;
    logic [7:0]  vec_type;

    int errors = 0, checks = 0;
    bit finished = 0;
    int lat = 1;

    always #2.5 clk = ~clk;

    irq_vector_fetch uut (
        .clk(clk), .rst(rst), .fault_div(fault_div), .soft_req(soft_req),
        .soft_type(soft_type), .nmi_in(nmi_in), .mint_req(mint_req),
        .mint_type(mint_type), .mint_en(mint_en), .trace_step(trace_step),
        .rd_req(rd_req), .rd_addr(rd_addr), .rd_valid(rd_valid), .rd_data(rd_data),
        .svc_ack(svc_ack), .vec_valid(vec_valid), .vec_type(vec_type),
        .vec_ip(vec_ip), .vec_cs(vec_cs)
    );

    function automatic logic [15:0] mem_word(int a);
        int v = a * 40503 + 777;
        return v[15:0];
    endfunction

    task automatic chk(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // memory model: answers each read after lat cycles
    int mem_cnt = 0;
    int mem_a = 0;
    int addr_log[$];
    always @(negedge clk) begin
        rd_valid <= 1'b0;
        if (mem_cnt > 0) begin
            mem_cnt = mem_cnt - 1;
            if (mem_cnt == 0) begin
                rd_valid <= 1'b1;
                rd_data  <= mem_word(mem_a);
            end
        end
        if (!rst && rd_req) begin
            mem_cnt = lat;
            mem_a   = int'(rd_addr);
            addr_log.push_back(int'(rd_addr));
        end
    end

    // behavioural reference, advanced on every rising edge
    int m_ph = 0, m_type = 0, m_ip = 0, m_cs = 0;
    bit m_pend = 0, m_prev = 0;
    always @(posedge clk) begin
        int w;
        bit w_nmi;
        if (rst) begin
            m_ph = 0; m_type = 0; m_ip = 0; m_cs = 0; m_pend = 0; m_prev = 0;
        end else begin
            w = -1; w_nmi = 0;
            if (fault_div)               w = 0;
            else if (soft_req)           w = int'(soft_type);
            else if (m_pend) begin       w = 2; w_nmi = 1; end
            else if (mint_req && mint_en) w = int'(mint_type);
            else if (trace_step)         w = 1;
            case (m_ph)
                0: if (w >= 0) begin m_type = w; m_ph = 1; end
                1: m_ph = 2;
                2: if (rd_valid) begin m_ip = int'(rd_data); m_ph = 3; end
                3: m_ph = 4;
                4: if (rd_valid) begin m_cs = int'(rd_data); m_ph = 5; end
                5: m_ph = svc_ack ? 0 : 6;
                6: if (svc_ack) m_ph = 0;
                default: m_ph = 0;
            endcase
            if (m_ph == 1 && w_nmi) m_pend = 0;
            if (nmi_in && !m_prev) m_pend = 1;
            m_prev = nmi_in;
        end
    end

    // per-cycle comparison against the reference
    always @(negedge clk) begin
        if (!rst && !finished) begin
            chk(rd_req === (m_ph == 1 || m_ph == 3), "R5 rd_req", int'(rd_req), int'(m_ph == 1 || m_ph == 3));
            if (m_ph == 1 || m_ph == 3)
                chk(int'(rd_addr) == m_type * 4 + (m_ph == 3 ? 2 : 0), "R5 rd_addr",
                    int'(rd_addr), m_type * 4 + (m_ph == 3 ? 2 : 0));
            chk(vec_valid === (m_ph == 5), "R6 vec_valid", int'(vec_valid), int'(m_ph == 5));
            if (m_ph == 5 || m_ph == 6) begin
                chk(int'(vec_type) == m_type, "R2 vec_type", int'(vec_type), m_type);
                chk(int'(vec_ip) == m_ip, "R6 vec_ip", int'(vec_ip), m_ip);
                chk(int'(vec_cs) == m_cs, "R6 vec_cs", int'(vec_cs), m_cs);
            end
        end
    end

    // wait for a delivery, check it, acknowledge and drop the served request
    task automatic serve(int exp, int src, int hold, string req);
        int n = 0;
        while (vec_valid !== 1'b1 && n < 300) begin
            @(negedge clk);
            n++;
        end
        chk(vec_valid === 1'b1, req, int'(vec_valid), 1);
        chk(int'(vec_type) == exp, req, int'(vec_type), exp);
        chk(vec_ip == mem_word(exp * 4), "R6 offset word", int'(vec_ip), int'(mem_word(exp * 4)));
        chk(vec_cs == mem_word(exp * 4 + 2), "R6 segment word", int'(vec_cs), int'(mem_word(exp * 4 + 2)));
        for (int k = 0; k < hold; k++) begin
            @(negedge clk);
            chk(rd_req === 1'b0, "R7 no read while unacknowledged", int'(rd_req), 0);
            chk(int'(vec_type) == exp, "R7 type held", int'(vec_type), exp);
        end
        svc_ack = 1'b1;
        case (src)
            0: fault_div = 0;
            1: soft_req = 0;
            3: mint_req = 0;
            4: trace_step = 0;
            default: ;
        endcase
        @(negedge clk);
        svc_ack = 1'b0;
    endtask

    task automatic quiet(int n, string req);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            chk(rd_req === 1'b0 && vec_valid === 1'b0, req, int'({rd_req, vec_valid}), 0);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R8: reset state
        chk(rd_req === 1'b0, "R8 rd_req in reset", int'(rd_req), 0);
        chk(vec_valid === 1'b0, "R8 vec_valid in reset", int'(vec_valid), 0);
        chk(vec_ip == 0 && vec_cs == 0 && vec_type == 0, "R8 vector cleared",
            int'({vec_type, vec_ip, vec_cs}), 0);
        rst = 1'b0;
        quiet(4, "R8 idle after reset");

        // R2/R3: maskable with enable, type 3 addresses 0x0C and 0x0E (R5)
        lat = 2;
        addr_log.delete();
        mint_en = 1; mint_type = 8'h03; mint_req = 1;
        serve(3, 3, 0, "R2 maskable type");
        chk(addr_log.size() == 2, "R5 two reads", addr_log.size(), 2);
        if (addr_log.size() == 2) begin
            chk(addr_log[0] == 'h0C, "R5 offset address", addr_log[0], 'h0C);
            chk(addr_log[1] == 'h0E, "R5 segment address", addr_log[1], 'h0E);
        end

        // R3: masked line has no effect
        mint_en = 0; mint_type = 8'h45; mint_req = 1;
        quiet(20, "R3 masked line ignored");
        mint_en = 1;
        serve(8'h45, 3, 0, "R3 unmasked line taken");

        // R1: all sources at once
        lat = 1;
        @(negedge clk);
        fault_div = 1; soft_req = 1; soft_type = 8'h21; nmi_in = 1;
        mint_req = 1; mint_type = 8'h80; mint_en = 1; trace_step = 1;
        @(negedge clk);
        nmi_in = 0;
        serve(0, 0, 0, "R1 divide error first");
        serve(8'h21, 1, 0, "R1 software second");
        serve(2, 2, 0, "R1 non-maskable third");
        serve(8'h80, 3, 0, "R1 maskable fourth");
        serve(1, 4, 0, "R1 single-step last");
        quiet(6, "R1 nothing left");

        // R4: held non-maskable level serves once, even with mask off (R3)
        mint_en = 0;
        nmi_in = 1;
        serve(2, 2, 0, "R4 non-maskable unmaskable");
        quiet(30, "R4 single service per edge");
        nmi_in = 0;
        quiet(3, "R4 falling edge no service");

        // R9: edge during a fetch is remembered; boundary type 255 (R5)
        lat = 3;
        addr_log.delete();
        soft_type = 8'hFF; soft_req = 1;
        while (rd_req !== 1'b1) @(negedge clk);
        nmi_in = 1;
        @(negedge clk);
        nmi_in = 0;
        serve(8'hFF, 1, 0, "R9 current service first");
        if (addr_log.size() >= 2) begin
            chk(addr_log[0] == 'h3FC, "R5 top entry offset", addr_log[0], 'h3FC);
            chk(addr_log[1] == 'h3FE, "R5 top entry segment", addr_log[1], 'h3FE);
        end else chk(0, "R5 top entry reads", addr_log.size(), 2);
        serve(2, 2, 0, "R9 remembered edge served");

        // R7: no new fetch until acknowledged, even with a source pending
        lat = 1;
        mint_en = 1; mint_type = 8'h33; mint_req = 1;
        trace_step = 1;
        serve(8'h33, 3, 12, "R7 held result");
        serve(1, 4, 0, "R7 pending step after ack");
        quiet(5, "R7 idle again");

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            errors++;
            checks++;
            $display("FAIL watchdog: run did not complete");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule